// File: doc/BRIEF.md
# Flash Controller Status Register with Ready/Busy Pin

This block is the status side of a flash controller's write state machine. It follows operation events from the sequencer: an accepted write or erase sequence, completion with or without failure, erase suspend and resume, an improperly entered erase sequence, and the supply-sense level at acceptance. It condenses them into an 8-bit status byte that a host reads to poll for completion and check for errors. The error flags hold their value until the host issues a clear command.

The block also drives a ready/busy pin. The pin can follow the ready state as a level, give one fixed-length pulse when an operation completes, give one fixed-length pulse when an operation starts, or stay inactive. A bank of per-block lock bits comes up locked on reset. It changes only when an upload command copies the real lock values in. Array timing and analog supply detection are outside the block and reach it only as input events.

Top module: `fsr_status_top`

## Requirements
- R1: `status_o` bit 7 is ready (1) or busy (0), bit 6 is erase suspended, bit 5 is erase failure, bit 4 is write failure, bit 3 is supply low with abort, and bits 2..0 always read 0. After reset `status_o` is 0x80.
- R2: `op_start_i` is accepted only while the block is ready and not suspended. An accepted start with `vpp_low_i`=0 makes bit 7 read 0 from the next cycle on. A start at any other time has no effect.
- R3: `vpp_low_i` is sampled only when a start is accepted. If it is 1 at that point, bit 3 is set together with the failure bit of the requested kind (`op_erase_i`=1 erase, 0 write), and the block stays ready. At any other time `vpp_low_i` has no effect.
- R4: `op_done_i` while busy returns the block to ready. If `op_fail_i` is also 1, bit 5 is set for an erase and bit 4 for a write. `op_done_i` while not busy has no effect.
- R5: `susp_i` while an erase is busy (and `op_done_i`=0) sets bit 6 and bit 7. `resume_i` while suspended clears bit 6 and makes the block busy again. `susp_i` during a write has no effect.
- R6: `seq_bad_i` while not busy sets bits 5 and 4 together.
- R7: Bits 5..3 are sticky across later operations. `clr_status_i` clears them in the next cycle. A set in the same cycle as a clear takes precedence.
- R8: After reset every bit of `lock_o` is 1. `upload_i` loads `upload_lock_i` into `lock_o` in the next cycle. Without `upload_i`, `lock_o` does not change.
- R9: `rb_cfg_we_i` loads the pin mode from `rb_cfg_i`: 0 level, 1 pulse on completion, 2 pulse on start, 3 disabled. The mode after reset is level. In level mode `rdy_bsy_o` equals status bit 7.
- R10: In a pulse mode `rdy_bsy_o` is 0 when idle. It is 1 for exactly PULSE_LEN cycles starting the cycle after the event: a busy-to-ready completion by `op_done_i` in mode 1, an accepted start without abort in mode 2. A new event restarts the count. A mode write cancels a running pulse.
- R11: In disabled mode `rdy_bsy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_start_i | input | 1 | Write or erase sequence accepted by the sequencer |
| op_erase_i | input | 1 | Kind of started operation: 1 erase, 0 write |
| vpp_low_i | input | 1 | Programming supply below threshold |
| op_done_i | input | 1 | Running operation finished |
| op_fail_i | input | 1 | Finished operation failed |
| susp_i | input | 1 | Erase suspend request |
| resume_i | input | 1 | Erase resume request |
| seq_bad_i | input | 1 | Improperly entered erase sequence |
| clr_status_i | input | 1 | Clear error flags |
| rb_cfg_we_i | input | 1 | Load ready/busy pin mode |
| rb_cfg_i | input | 2 | Ready/busy pin mode code |
| upload_i | input | 1 | Load lock bits |
| upload_lock_i | input | NUM_BLOCKS | Real lock values |
| status_o | output | 8 | Status byte |
| lock_o | output | NUM_BLOCKS | Per-block lock bits |
| rdy_bsy_o | output | 1 | Ready/busy pin |

## Verification
Each state bit in this block reaches the ports in the cycle after it changes. A wrong busy or suspend state therefore shows up on bit 7, on bit 6 or on the level-mode pin one cycle after the event that caused it. A wrong sticky flag stays visible on status bits 5..3 until the next clear, so a missed or spurious set is not hidden by later operations. Pulse-counter errors show as a pulse that is too long, too short or out of place on the pin. Because the reference model is compared on every clock, any of these errors is reported within one cycle of the first wrong value.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    RB_LEVEL       = 2'd0,
    RB_PULSE_DONE  = 2'd1,
    RB_PULSE_START = 2'd2,
    RB_OFF         = 2'd3
  } rb_mode_e;

  typedef struct packed {
    logic       ready;
    logic       susp;
    logic       erase_err;
    logic       write_err;
    logic       vpp_low;
    logic [2:0] rsvd;
  } stat_t;
endpackage

// File: rtl/fsr_wsm_track.sv
module fsr_wsm_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic erase_i,
  input  logic vpp_low_i,
  input  logic done_i,
  input  logic susp_i,
  input  logic resume_i,
  output logic busy_o,
  output logic susp_o,
  output logic kind_erase_o,
  output logic run_o,
  output logic abort_o,
  output logic done_ev_o
);
  logic busy_q, susp_q, erase_q;
  logic accept, susp_ev, res_ev;

  assign accept    = start_i & ~busy_q & ~susp_q;
  assign run_o     = accept & ~vpp_low_i;
  assign abort_o   = accept & vpp_low_i;
  assign done_ev_o = done_i & busy_q;
  assign susp_ev   = susp_i & busy_q & erase_q & ~done_i;
  assign res_ev    = resume_i & susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      susp_q  <= 1'b0;
      erase_q <= 1'b0;
    end else begin
      if (run_o || res_ev)            busy_q <= 1'b1;
      else if (done_ev_o || susp_ev)  busy_q <= 1'b0;
      if (susp_ev)                    susp_q <= 1'b1;
      else if (res_ev)                susp_q <= 1'b0;
      if (run_o)                      erase_q <= erase_i;
    end
  end

  assign busy_o       = busy_q;
  assign susp_o       = susp_q;
  assign kind_erase_o = erase_q;
endmodule

// File: rtl/fsr_err_flags.sv
module fsr_err_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic done_ev_i,
  input  logic fail_i,
  input  logic kind_erase_i,
  input  logic abort_i,
  input  logic abort_erase_i,
  input  logic bad_seq_i,
  output logic es_o,
  output logic dws_o,
  output logic vpps_o
);
  logic es_q, dws_q, vpps_q;
  logic set_es, set_dws;

  // a failed completion or an aborted start flags the kind involved
  assign set_es  = (done_ev_i & fail_i & kind_erase_i) | (abort_i & abort_erase_i) | bad_seq_i;
  assign set_dws = (done_ev_i & fail_i & ~kind_erase_i) | (abort_i & ~abort_erase_i) | bad_seq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      es_q   <= 1'b0;
      dws_q  <= 1'b0;
      vpps_q <= 1'b0;
    end else begin
      es_q   <= (es_q & ~clr_i) | set_es;
      dws_q  <= (dws_q & ~clr_i) | set_dws;
      vpps_q <= (vpps_q & ~clr_i) | abort_i;
    end
  end

  assign es_o   = es_q;
  assign dws_o  = dws_q;
  assign vpps_o = vpps_q;
endmodule

// File: rtl/fsr_lock_bank.sv
module fsr_lock_bank #(
  parameter int unsigned NUM_BLOCKS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NUM_BLOCKS-1:0] val_i,
  output logic [NUM_BLOCKS-1:0] lock_o
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic lk_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     lk_q <= 1'b1;
      else if (load_i) lk_q <= val_i[b];
    end
    assign lock_o[b] = lk_q;
  end
endmodule

// File: rtl/fsr_rb_drive.sv
module fsr_rb_drive
  import fsr_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cfg_we_i,
  input  logic [1:0] cfg_i,
  input  logic     busy_i,
  input  logic     start_ev_i,
  input  logic     done_ev_i,
  output rb_mode_e mode_o,
  output logic     rb_o
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_LEN);

  rb_mode_e mode_q;
  logic [CW-1:0] cnt_q;
  logic trig;

  assign trig = (mode_q == RB_PULSE_DONE  && done_ev_i) ||
                (mode_q == RB_PULSE_START && start_ev_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RB_LEVEL;
      cnt_q  <= '0;
    end else if (cfg_we_i) begin
      mode_q <= rb_mode_e'(cfg_i);
      cnt_q  <= '0;
    end else if (trig) begin
      cnt_q  <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    unique case (mode_q)
      RB_LEVEL:       rb_o = ~busy_i;
      RB_PULSE_DONE,
      RB_PULSE_START: rb_o = (cnt_q != '0);
      default:        rb_o = 1'b0;
    endcase
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/fsr_status_top.sv
module fsr_status_top
  import fsr_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 16,
  parameter int unsigned PULSE_LEN  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  op_start_i,
  input  logic                  op_erase_i,
  input  logic                  vpp_low_i,
  input  logic                  op_done_i,
  input  logic                  op_fail_i,
  input  logic                  susp_i,
  input  logic                  resume_i,
  input  logic                  seq_bad_i,
  input  logic                  clr_status_i,
  input  logic                  rb_cfg_we_i,
  input  logic [1:0]            rb_cfg_i,
  input  logic                  upload_i,
  input  logic [NUM_BLOCKS-1:0] upload_lock_i,
  output logic [7:0]            status_o,
  output logic [NUM_BLOCKS-1:0] lock_o,
  output logic                  rdy_bsy_o
);
  logic busy, susp, kind_erase, run_ev, abort_ev, done_ev, bad_ev;
  logic es, dws, vpps;
  rb_mode_e rb_mode;
  stat_t stat;

  fsr_wsm_track u_wsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (op_start_i),
    .erase_i     (op_erase_i),
    .vpp_low_i   (vpp_low_i),
    .done_i      (op_done_i),
    .susp_i      (susp_i),
    .resume_i    (resume_i),
    .busy_o      (busy),
    .susp_o      (susp),
    .kind_erase_o(kind_erase),
    .run_o       (run_ev),
    .abort_o     (abort_ev),
    .done_ev_o   (done_ev)
  );

  assign bad_ev = seq_bad_i & ~busy;

  fsr_err_flags u_err (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr_status_i),
    .done_ev_i    (done_ev),
    .fail_i       (op_fail_i),
    .kind_erase_i (kind_erase),
    .abort_i      (abort_ev),
    .abort_erase_i(op_erase_i),
    .bad_seq_i    (bad_ev),
    .es_o         (es),
    .dws_o        (dws),
    .vpps_o       (vpps)
  );

  fsr_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(upload_i),
    .val_i (upload_lock_i),
    .lock_o(lock_o)
  );

  fsr_rb_drive #(.PULSE_LEN(PULSE_LEN)) u_rb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (rb_cfg_we_i),
    .cfg_i     (rb_cfg_i),
    .busy_i    (busy),
    .start_ev_i(run_ev),
    .done_ev_i (done_ev),
    .mode_o    (rb_mode),
    .rb_o      (rdy_bsy_o)
  );

  always_comb begin
    stat.ready     = ~busy;
    stat.susp      = susp;
    stat.erase_err = es;
    stat.write_err = dws;
    stat.vpp_low   = vpps;
    stat.rsvd      = '0;
  end
  assign status_o = stat;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int unsigned NUM_BLOCKS = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  op_start_i,
  input logic                  op_done_i,
  input logic                  seq_bad_i,
  input logic                  clr_status_i,
  input logic                  upload_i,
  input logic [NUM_BLOCKS-1:0] upload_lock_i,
  input logic [7:0]            status_o,
  input logic [NUM_BLOCKS-1:0] lock_o,
  input logic                  rdy_bsy_o,
  input logic [1:0]            rb_mode
);
  always_comb begin
    if (rst_ni) AST_RSV_ZERO: assert (status_o[2:0] == 3'b000); // R1
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[7] && !status_o[6] && !op_done_i |=> !status_o[7] || status_o[6]); // R2

  AST_BAD_SETS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_bad_i && status_o[7] |=> status_o[5] && status_o[4]); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] && !clr_status_i |=> status_o[5]); // R7

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_status_i && !op_start_i && !op_done_i && !seq_bad_i |=> status_o[5:3] == 3'b000); // R7

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upload_i |=> $stable(lock_o)); // R8

  AST_LOCK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upload_i |=> lock_o == $past(upload_lock_i)); // R8

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_mode == 2'd0 |-> rdy_bsy_o == status_o[7]); // R9

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rb_mode == 2'd3 |-> !rdy_bsy_o); // R11
endmodule

bind fsr_status_top fsr_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_fsr_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_start_i   (op_start_i),
  .op_done_i    (op_done_i),
  .seq_bad_i    (seq_bad_i),
  .clr_status_i (clr_status_i),
  .upload_i     (upload_i),
  .upload_lock_i(upload_lock_i),
  .status_o     (status_o),
  .lock_o       (lock_o),
  .rdy_bsy_o    (rdy_bsy_o),
  .rb_mode      (rb_mode)
);

// File: tb/fsr_status_top_tb_top.sv
module fsr_status_top_tb_top;
  localparam int NB = 16;
  localparam int PL = 4;

  logic clk = 0, rst_n = 0;
  logic st = 0, er = 0, vl = 0, dn = 0, fl = 0, sp = 0, rs = 0, bad = 0, clr = 0;
  logic cwe = 0, upl = 0;
  logic [1:0] cfg = 0;
  logic [NB-1:0] ulk = 0;
  logic [7:0] status;
  logic [NB-1:0] lock;
  logic rb;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  fsr_status_top #(.NUM_BLOCKS(NB), .PULSE_LEN(PL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_start_i(st), .op_erase_i(er), .vpp_low_i(vl),
    .op_done_i(dn), .op_fail_i(fl), .susp_i(sp), .resume_i(rs), .seq_bad_i(bad),
    .clr_status_i(clr), .rb_cfg_we_i(cwe), .rb_cfg_i(cfg), .upload_i(upl),
    .upload_lock_i(ulk), .status_o(status), .lock_o(lock), .rdy_bsy_o(rb)
  );

  // behavioural reference
  bit m_busy, m_ess, m_kind, m_es, m_dws, m_vp;
  int m_mode, m_cnt;
  logic [NB-1:0] m_lock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ess = 0; m_kind = 0; m_es = 0; m_dws = 0; m_vp = 0;
      m_mode = 0; m_cnt = 0; m_lock = '1;
    end else begin
      bit acc, abrt, go, fin, hold, back, wrong;
      acc   = st && !m_busy && !m_ess;
      abrt  = acc && vl;
      go    = acc && !vl;
      fin   = dn && m_busy;
      hold  = sp && m_busy && m_kind && !dn;
      back  = rs && m_ess;
      wrong = bad && !m_busy;
      if (clr) begin m_es = 0; m_dws = 0; m_vp = 0; end
      if (fin && fl) begin if (m_kind) m_es = 1; else m_dws = 1; end
      if (abrt) begin m_vp = 1; if (er) m_es = 1; else m_dws = 1; end
      if (wrong) begin m_es = 1; m_dws = 1; end
      if (cwe) begin m_mode = cfg; m_cnt = 0; end
      else if ((m_mode == 1 && fin) || (m_mode == 2 && go)) m_cnt = PL;
      else if (m_cnt > 0) m_cnt--;
      if (go) m_kind = er;
      if (go || back) m_busy = 1;
      else if (fin || hold) m_busy = 0;
      if (hold) m_ess = 1; else if (back) m_ess = 0;
      if (upl) m_lock = ulk;
    end
  end

  function automatic logic [7:0] m_stat();
    return {!m_busy, m_ess, m_es, m_dws, m_vp, 3'b000};
  endfunction

  function automatic bit m_rb();
    case (m_mode)
      0: return !m_busy;
      1, 2: return m_cnt > 0;
      default: return 0;
    endcase
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    logic [7:0] e, d;
    e = m_stat();
    d = e ^ status;
    checks++;
    if (d != 0) begin
      fails++;
      if (d[7])        $display("FAIL R2 ready bit act=%h exp=%h", status, e);
      else if (d[6])   $display("FAIL R5 suspend bit act=%h exp=%h", status, e);
      else if (d[5:4]) $display("FAIL R4 error bits act=%h exp=%h", status, e);
      else if (d[3])   $display("FAIL R3 supply bit act=%h exp=%h", status, e);
      else             $display("FAIL R1 reserved bits act=%h exp=%h", status, e);
    end
    checks++;
    if (lock !== m_lock) begin
      fails++; $display("FAIL R8 lock act=%h exp=%h", lock, m_lock);
    end
    checks++;
    if (rb !== m_rb()) begin
      fails++;
      $display("FAIL %s rdy_bsy act=%b exp=%b mode=%0d", m_mode == 3 ? "R11" :
               (m_mode == 0 ? "R9" : "R10"), rb, m_rb(), m_mode);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    st = 0; dn = 0; fl = 0; sp = 0; rs = 0; bad = 0; clr = 0; cwe = 0; upl = 0; vl = 0;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 reset status", status, 8'h80);
    chk("R8 reset lock", lock, {NB{1'b1}});
    chk("R9 reset level pin", rb, 1);
    // R2 write start, R4 failed done
    st = 1; er = 0; step(1); idle();
    chk("R2 busy after start", status, 8'h00);
    st = 1; step(1); idle();
    chk("R2 start while busy ignored", status, 8'h00);
    dn = 1; fl = 1; step(1); idle();
    chk("R4 write failure", status, 8'h90);
    // R7 sticky then clear
    st = 1; er = 1; step(1); idle(); dn = 1; step(1); idle();
    chk("R7 sticky write flag", status, 8'h90);
    clr = 1; step(1); idle();
    chk("R7 cleared", status, 8'h80);
    // R3 supply low at acceptance
    st = 1; er = 1; vl = 1; step(1); idle();
    chk("R3 abort flags", status, 8'hA8);
    clr = 1; step(1); idle();
    vl = 1; step(2); idle();
    chk("R3 supply ignored when idle", status, 8'h80);
    // R6 improper sequence
    bad = 1; step(1); idle();
    chk("R6 both bits", status, 8'hB0);
    clr = 1; step(1); idle();
    // R5 suspend / resume
    st = 1; er = 1; step(1); idle();
    sp = 1; step(1); idle();
    chk("R5 suspended", status, 8'hC0);
    rs = 1; step(1); idle();
    chk("R5 resumed", status, 8'h00);
    dn = 1; step(1); idle();
    // R10 completion pulse
    cwe = 1; cfg = 1; step(1); idle();
    chk("R10 idle low", rb, 0);
    st = 1; er = 0; step(1); idle(); dn = 1; step(1); idle();
    for (int i = 0; i < PL; i++) begin chk("R10 pulse high", rb, 1); step(1); end
    chk("R10 pulse end", rb, 0);
    // R11 disabled
    cwe = 1; cfg = 3; step(1); idle();
    st = 1; step(1); idle(); dn = 1; step(1); idle();
    chk("R11 pin quiet", rb, 0);
    // R8 upload
    ulk = 16'hA5C3; upl = 1; step(1); idle();
    chk("R8 upload", lock, 16'hA5C3);
    ulk = 16'h0000; step(2);
    chk("R8 hold", lock, 16'hA5C3);
    // random phase against the reference model
    for (int i = 0; i < 6000; i++) begin
      st  = ($urandom % 6) == 0;
      er  = $urandom % 2;
      vl  = ($urandom % 6) == 0;
      dn  = ($urandom % 5) == 0;
      fl  = ($urandom % 3) == 0;
      sp  = ($urandom % 10) == 0;
      rs  = ($urandom % 6) == 0;
      bad = ($urandom % 40) == 0;
      clr = ($urandom % 15) == 0;
      cwe = ($urandom % 60) == 0;
      cfg = 2'($urandom % 4);
      upl = ($urandom % 50) == 0;
      ulk = NB'($urandom);
      step(1);
    end
    idle();
    step(PL + 2);
    finish_run();
  end
endmodule